// File: doc/BRIEF.md
# Quarter-Wave Difference-Table Sine Synthesiser

This block is a direct digital synthesis tone source. A wide phase accumulator adds a frequency tuning word on every sample strobe. The most significant bits of the accumulator form a lookup phase. That phase is turned into a signed sine sample by a small table plus reconstruction logic. The output is a registered sample with a valid flag. The sample rate is set by how often the strobe is raised. Because that rate is normally far below the clock rate, the lookup path sits idle most of the time and could be time-shared between several independent tones.

The table covers a single quadrant of the wave and is evaluated at the centre of each phase step. Each entry holds only the gap between the sine and the straight line from zero to full scale. That gap never exceeds about 21% of full scale, so an entry needs two bits fewer than the output.

Logic rebuilds the straight line from the address and adds it to the entry. Logic also mirrors the address in the falling quadrants and negates the result in the lower half-period. The table is computed during elaboration, with no external data. With the full-resolution setting, the lookup phase is 17 bits and the output is 16 bits. The default lookup phase is shorter so that the table stays modest.

Top module: `dds_sine_gen`

## Requirements
- R1: While `rst` is high on a clock edge, the design clears the accumulator, `sample` and `valid`. After that edge, `sample` is 0 and `valid` is 0.
- R2: On each clock edge with `en` high, the accumulator advances by `ftw` modulo 2^ACC_W. The lookup phase index p is the top LOOK_W bits of the accumulator, and the lower bits are discarded.
- R3: `sample` never takes the value -2^(OUT_W-1). Magnitudes are saturated to FS = 2^(OUT_W-1)-1.
- R4: `valid` first goes high on the third enabled edge after reset and stays high until the next reset. The sample presented after enabled edge k (k >= 3) belongs to the accumulator value that was held before enabled edge k-2. The first such value is the reset phase 0.
- R5: On a clock edge with `en` low, `sample` and `valid` keep their values.
- R6: The top two bits of p select the quadrant: 00 rising, 01 falling, 10 and 11 negated copies of 00 and 01. Two exact symmetries follow. sample(p + 2^(LOOK_W-1)) = -sample(p), and sample(p) = sample(2^(LOOK_W-1)-1-p) for p in the first half-period.
- R7: For each p, `sample` differs by at most 2 LSB from FS·sin(2π(p+0.5)/2^LOOK_W), rounded to the nearest integer.
- R8: `ftw` is sampled only on enabled edges. A new tuning word affects only the accumulator steps taken from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ftw | input | ACC_W | Frequency tuning word added per strobe |
| en | input | 1 | Sample strobe; advances accumulator and pipeline |
| sample | output | OUT_W | Signed sine sample, two's complement |
| valid | output | 1 | High once the pipeline holds a real sample |

## Verification
The bench runs a reduced configuration with a 10-bit lookup phase, so a unit phase step visits every index. A fold that mirrors the wrong quadrants, or mirrors by subtraction instead of inversion, breaks the exact mirror comparison. A missing negation breaks the half-period comparison. A rebuilt line with the wrong rounding or scale drifts beyond the 2 LSB bound near the quadrant edges. A wrong latency or a pipeline that runs without the strobe shows up as phase-shifted samples, or as samples that change during strobe gaps. Mid-run changes of the tuning word and a mid-stream reset exercise sampling of the tuning word and the clearing of all pipeline state.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam real TWO_PI_Q = 1.5707963267948966;

  // Rebuilt straight line at the centre of quarter-table step a:
  // round((a + 0.5) * fs / n) done as floor(((2a+1)*fs + n) / (2n))
  function automatic longint line_term(input longint a, input int addr_w, input longint fs);
    longint n;
    n = longint'(1) << addr_w;
    return (((2 * a) + 1) * fs + n) / (2 * n);
  endfunction

  // Full-scale sine of the centre of quarter-table step a, rounded
  function automatic longint sine_term(input longint a, input int addr_w, input longint fs);
    real n;
    real x;
    n = real'(longint'(1) << addr_w);
    x = real'(fs) * $sin(TWO_PI_Q * (real'(a) + 0.5) / n);
    return longint'($rtoi(x + 0.5));
  endfunction

  // Stored entry: sine minus line, never below zero on the concave quadrant
  function automatic longint quarter_entry(input longint a, input int addr_w, input longint fs);
    longint d;
    d = sine_term(a, addr_w, fs) - line_term(a, addr_w, fs);
    return (d < 0) ? 0 : d;
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W  = 32,
  parameter int LOOK_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ACC_W-1:0]  ftw,
  output logic [ACC_W-1:0]  acc_q,
  output logic [LOOK_W-1:0] phase
);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_q + ftw;
    end
  end

  assign phase = acc_q[ACC_W-1 -: LOOK_W];

endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom #(
  parameter int ADDR_W = 10,
  parameter int ENT_W  = 14,
  parameter int FS     = 32767
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [ENT_W-1:0]  data_q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ENT_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam longint VAL = dds_pkg::quarter_entry(longint'(g), ADDR_W, longint'(FS));
    assign tbl[g] = ENT_W'(VAL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (en) begin
      data_q <= tbl[addr];
    end
  end

endmodule

// File: rtl/dds_rebuild.sv
module dds_rebuild #(
  parameter int ADDR_W = 10,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [OUT_W-3:0]  entry,
  input  logic              neg,
  output logic [OUT_W-1:0]  result_q,
  output logic              sat_hit
);

  localparam int FS = (1 << (OUT_W - 1)) - 1;
  localparam int N  = 1 << ADDR_W;
  localparam int PW = ADDR_W + OUT_W + 1;

  logic [PW-1:0]    prod;
  logic [OUT_W-1:0] line;
  logic [OUT_W:0]   mag_w;
  logic [OUT_W-1:0] mag_s;
  logic [OUT_W-1:0] res;

  always_comb begin
    prod    = PW'({addr, 1'b1}) * PW'(FS) + PW'(N);
    line    = prod[PW-1 : ADDR_W+1];
    mag_w   = (OUT_W+1)'(line) + (OUT_W+1)'(entry);
    sat_hit = (mag_w > (OUT_W+1)'(FS));
    mag_s   = sat_hit ? OUT_W'(FS) : mag_w[OUT_W-1:0];
    res     = neg ? (~mag_s + OUT_W'(1)) : mag_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
    end else if (en) begin
      result_q <= res;
    end
  end

endmodule

// File: rtl/dds_sine_gen.sv
module dds_sine_gen #(
  parameter int ACC_W  = 32,
  parameter int LOOK_W = 12,
  parameter int OUT_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] ftw,
  input  logic             en,
  output logic [OUT_W-1:0] sample,
  output logic             valid
);

  localparam int ADDR_W = LOOK_W - 2;
  localparam int ENT_W  = OUT_W - 2;
  localparam int FS     = (1 << (OUT_W - 1)) - 1;

  logic [ACC_W-1:0]  acc_q;
  logic [LOOK_W-1:0] phase;
  logic [1:0]        s1_quad;
  logic [ADDR_W-1:0] s1_addr;
  logic [1:0]        s2_quad;
  logic [ADDR_W-1:0] s2_addr;
  logic [ENT_W-1:0]  s2_entry;
  logic [2:0]        vld_pipe;
  logic              s2_neg;
  logic              sat_hit;
  logic [ADDR_W-1:0] fold_addr;

  dds_phase_acc #(.ACC_W(ACC_W), .LOOK_W(LOOK_W)) u_acc (
    .clk(clk), .rst(rst), .en(en), .ftw(ftw), .acc_q(acc_q), .phase(phase)
  );

  // quadrant fold: odd quadrants run the address backwards
  assign fold_addr = phase[ADDR_W-1:0] ^ {ADDR_W{phase[LOOK_W-2]}};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_quad  <= '0;
      s1_addr  <= '0;
      s2_quad  <= '0;
      s2_addr  <= '0;
      vld_pipe <= '0;
    end else if (en) begin
      s1_quad  <= phase[LOOK_W-1 -: 2];
      s1_addr  <= fold_addr;
      s2_quad  <= s1_quad;
      s2_addr  <= s1_addr;
      vld_pipe <= {vld_pipe[1:0], 1'b1};
    end
  end

  dds_quarter_rom #(.ADDR_W(ADDR_W), .ENT_W(ENT_W), .FS(FS)) u_rom (
    .clk(clk), .rst(rst), .en(en), .addr(s1_addr), .data_q(s2_entry)
  );

  assign s2_neg = s2_quad[1];

  dds_rebuild #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_rebuild (
    .clk(clk), .rst(rst), .en(en), .addr(s2_addr), .entry(s2_entry),
    .neg(s2_neg), .result_q(sample), .sat_hit(sat_hit)
  );

  assign valid = vld_pipe[2];

endmodule

// File: rtl/dds_sine_gen_chk.sv
module dds_sine_gen_chk #(
  parameter int ACC_W = 32,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [ACC_W-1:0] ftw,
  input logic [ACC_W-1:0] acc_q,
  input logic [OUT_W-1:0] sample,
  input logic             valid,
  input logic             s2_neg
);

  localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  assert_acc_step_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> acc_q == $past(acc_q) + $past(ftw));

  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> acc_q == $past(acc_q));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    valid |-> sample != MOST_NEG);

  assert_valid_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(en));

  assert_valid_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sample) && $stable(valid));

  assert_neg_half_R6: assert property (@(posedge clk) disable iff (rst)
    en && s2_neg |=> $signed(sample) <= 0);

  assert_pos_half_R6: assert property (@(posedge clk) disable iff (rst)
    en && !s2_neg |=> $signed(sample) >= 0);

endmodule

bind dds_sine_gen dds_sine_gen_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .ftw(ftw), .acc_q(acc_q),
  .sample(sample), .valid(valid), .s2_neg(s2_neg)
);

// File: tb/tb_dds_sine_gen.sv
module tb_dds_sine_gen;

  localparam int  ACC_W  = 16;
  localparam int  LOOK_W = 10;
  localparam int  OUT_W  = 16;
  localparam int  FS     = (1 << (OUT_W - 1)) - 1;
  localparam int  NP     = 1 << LOOK_W;
  localparam time TCLK   = 10;

  logic             clk = 0;
  logic             rst = 1;
  logic [ACC_W-1:0] ftw = '0;
  logic             en  = 0;
  logic [OUT_W-1:0] sample;
  logic             valid;

  int total = 0;
  int bad   = 0;

  int acc_m;
  int nen;
  int pq[$];
  int seen [NP];
  bit have [NP];

  dds_sine_gen #(.ACC_W(ACC_W), .LOOK_W(LOOK_W), .OUT_W(OUT_W)) dut (
    .clk(clk), .rst(rst), .ftw(ftw), .en(en), .sample(sample), .valid(valid)
  );

  always #(TCLK/2) clk = ~clk;

  function automatic int ref_sine(input int p);
    real x;
    x = real'(FS) * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / real'(NP));
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; en = 0;
    @(posedge clk); @(negedge clk);
    rst = 0;
    acc_m = 0; nen = 0; pq.delete();
    check(valid == 0, "R1 valid", int'(valid), 0);
    check(sample == 0, "R1 sample", int'($signed(sample)), 0);
  endtask

  // one clock with the strobe e; checks output after the edge
  task automatic step(input bit e);
    int p, want, got;
    logic [OUT_W-1:0] prev_s;
    bit prev_v;
    @(negedge clk);
    en = e;
    prev_s = sample; prev_v = valid;
    if (e) begin
      pq.push_back(acc_m);
      acc_m = (acc_m + int'(ftw)) % (1 << ACC_W);
      nen++;
    end
    @(posedge clk); #1;
    if (!e) begin
      check(sample == prev_s && valid == prev_v, "R5 hold", int'($signed(sample)), int'($signed(prev_s)));
    end else if (nen < 3) begin
      check(valid == 0, "R4 early valid", int'(valid), 0);
    end else begin
      check(valid == 1, "R4 valid", int'(valid), 1);
      p    = pq[nen-3] >> (ACC_W - LOOK_W);
      want = ref_sine(p);
      got  = int'($signed(sample));
      check(got - want <= 2 && want - got <= 2, "R7 R2 accuracy", got, want);
      check(got != -(FS + 1), "R3 range", got, -FS);
      seen[p] = got; have[p] = 1;
    end
  endtask

  initial begin
    #(TCLK * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // unit phase step: exhaustive sweep of every index (R2, R7)
    ftw = ACC_W'(1 << (ACC_W - LOOK_W));
    for (int i = 0; i < NP + 3; i++) step(1);
    // exact symmetries over the swept table (R6)
    for (int p = 0; p < NP / 2; p++)
      check(have[p] && have[p + NP/2] && seen[p + NP/2] == -seen[p], "R6 half-period", seen[p + NP/2], -seen[p]);
    for (int p = 0; p < NP / 4; p++)
      check(seen[p] == seen[NP/2 - 1 - p], "R6 mirror", seen[NP/2 - 1 - p], seen[p]);
    // strobe gaps hold the output (R5)
    for (int i = 0; i < 40; i++) step((i % 3) == 0);
    // fractional tuning word, truncated low bits (R2)
    ftw = ACC_W'(7 * 64 + 13);
    for (int i = 0; i < 600; i++) step(1);
    // tuning word change mid-run, taking effect from the next strobe (R8)
    ftw = ACC_W'(3001);
    for (int i = 0; i < 6; i++) step(i != 2);
    ftw = ACC_W'(65535);
    for (int i = 0; i < 300; i++) step(1);
    // mid-stream reset clears everything (R1) and restarts latency (R4)
    do_reset();
    ftw = ACC_W'(12345);
    for (int i = 0; i < 400; i++) step(1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule